// File: doc/BRIEF.md
# SPI Register-Access Frame Slave

This block is an SPI mode-0 slave that turns register-access frames from an external master into single-byte accesses on a simple internal bus. While chip select is low, a frame carries three parts: a 16-bit start address (high byte first), then one control byte, then a data burst of any length. The control byte picks one of 32 address blocks, the transfer direction and a burst-length mode.

On a write frame, each data byte that is fully received raises a one-cycle write strobe with the byte, the block and the current address. On a read frame, the slave fetches each byte from the bus before the master clocks it. It then shifts the byte out on MISO, most significant bit first. The bus address steps by one after every access and wraps at the top of the 16-bit space. Fixed-length modes cap how many accesses a burst may make. Blocks that decode to a reserved code never reach the bus.

The SPI pins are brought into the system clock domain through synchronisers and edge detectors. Each SCLK phase must therefore last at least 8 system clock periods. MISO is always driven, and reads 0 whenever no read data is being shifted out.

Top module: `spi_frame_slave`

## Requirements
- R1: A frame is the start address (ADDR_W/8 bytes, most significant byte first), then a control byte, then data bytes. The first bus access uses that start address. bus_blk carries control bits [7:3].
- R2: Control bit 2 set to 1 selects write. Each data byte fully received in a write frame gives one bus_wr pulse, with bus_wdata equal to that byte.
- R3: Control bit 2 at 0 selects read. The first bus_rd is issued after the control byte, before the first data bit. Each fetched byte appears on MISO MSB first, valid at the SCLK rising edges. MOSI bytes sent during a read data phase cause no write. A read frame makes one fetch more than its data bytes (min(N+1, limit) fetches), because each fetch runs one byte ahead.
- R4: Successive accesses in a frame use consecutive addresses. 0xFFFF is followed by 0x0000.
- R5: Length mode 00 (control bits [1:0]) lets the burst run for as many data bytes as the master clocks.
- R6: Length modes 01, 10 and 11 allow at most 1, 2 and 4 accesses. Later write bytes make no strobe, and later read bytes return 0x00.
- R7: Chip select going high ends the frame at once. A partly received byte is dropped without a strobe, and the next frame starts again from the address phase.
- R8: A block code with bits [1:0] equal to 00 and a nonzero value is reserved. Such a frame makes no bus access, and its read bytes return 0x00.
- R9: bus_wr and bus_rd each last one cycle, are never high together, and occur only while chip select is low.
- R10: After reset, bus_wr, bus_rd, bus_addr, bus_blk, bus_wdata and MISO are all 0.
- R11: MISO is 0 during the address and control bytes and during the data phase of write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| bus_blk | output | 5 | Block select of the current access |
| bus_addr | output | ADDR_W | Address of the current access |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_wdata | output | 8 | Write data, valid with bus_wr |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_rdata | input | 8 | Read data, valid in the cycle after bus_rd |

## Verification
The bench builds the block with its defaults: ADDR_W of 16 and SYNC_STAGES of 2. The two-byte header then reaches the 0xFFFF-to-0x0000 wrap in both read and write bursts. The SCLK phases are 8 system clocks long, which is the shortest phase the prefetch path allows. Under these values the bench covers every length mode, the one-byte-ahead read fetch, reserved block codes, and aborts both inside the address bytes and inside a data byte.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

    localparam int BYTE_W     = 8;
    localparam int BLK_W      = 5;
    localparam int BITCNT_W   = $clog2(BYTE_W);
    localparam int BURST_W    = 3;
    localparam int CTL_DIR    = 2;

    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_CTRL = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // Maximum number of accesses for a fixed-length mode, 0 for open-ended
    function automatic logic [BURST_W-1:0] burst_limit(input logic [1:0] mode);
        case (mode)
            2'b01:   burst_limit = 3'd1;
            2'b10:   burst_limit = 3'd2;
            2'b11:   burst_limit = 3'd4;
            default: burst_limit = 3'd0;
        endcase
    endfunction

    function automatic logic blk_reserved(input logic [BLK_W-1:0] blk);
        blk_reserved = (blk[1:0] == 2'b00) && (blk != '0);
    endfunction

endpackage

// File: rtl/spi_frame_sync.sv
module spi_frame_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic cs_act_o,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic mosi_o
);

    typedef struct packed {
        logic [STAGES-1:0] sclk_p;
        logic [STAGES-1:0] cs_p;
        logic [STAGES-1:0] mosi_p;
        logic              sclk_last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.sclk_p    = STAGES'({s_q.sclk_p, sclk_i});
        s_d.cs_p      = STAGES'({s_q.cs_p, cs_n_i});
        s_d.mosi_p    = STAGES'({s_q.mosi_p, mosi_i});
        s_d.sclk_last = s_q.sclk_p[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sclk_p    <= '0;
            s_q.cs_p      <= '1;
            s_q.mosi_p    <= '0;
            s_q.sclk_last <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cs_act_o    = !s_q.cs_p[STAGES-1];
    assign sclk_rise_o =  s_q.sclk_p[STAGES-1] && !s_q.sclk_last;
    assign sclk_fall_o = !s_q.sclk_p[STAGES-1] &&  s_q.sclk_last;
    assign mosi_o      =  s_q.mosi_p[STAGES-1];

    assert_edge_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_rise_o |=> !sclk_rise_o);

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_frame_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi,
    input  logic              tx_load,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso
);

    typedef struct packed {
        logic [BITCNT_W-1:0] cnt;
        logic [BYTE_W-1:0]   rx_sh;
        logic [BYTE_W-1:0]   tx_sh;
        logic [BYTE_W-1:0]   rx_out;
        logic                done;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (!cs_act) begin
            s_d.cnt   = '0;
            s_d.rx_sh = '0;
            s_d.tx_sh = '0;
        end else begin
            if (sclk_rise) begin
                s_d.rx_sh = {s_q.rx_sh[BYTE_W-2:0], mosi};
                s_d.cnt   = s_q.cnt + 1'b1;
                if (s_q.cnt == BITCNT_W'(BYTE_W-1)) begin
                    s_d.done   = 1'b1;
                    s_d.rx_out = {s_q.rx_sh[BYTE_W-2:0], mosi};
                end
            end else if (sclk_fall && (s_q.cnt != '0)) begin
                s_d.tx_sh = {s_q.tx_sh[BYTE_W-2:0], 1'b0};
            end
            if (tx_load) begin
                s_d.tx_sh = tx_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_done = s_q.done;
    assign rx_byte   = s_q.rx_out;
    assign miso      = s_q.tx_sh[BYTE_W-1];

    // A completed byte only ever follows a sampling edge
    assert_done_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(sclk_rise));

    // A dropped frame never reports a byte
    assert_no_byte_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> $past(cs_act));

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_frame_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic              tx_load,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BLK_W-1:0]  bus_blk,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic              bus_rd
);

    localparam int ABYTES  = ADDR_W / BYTE_W;
    localparam int ABYTE_W = (ABYTES > 1) ? $clog2(ABYTES) : 1;

    typedef struct packed {
        phase_e              phase;
        logic [ABYTE_W-1:0]  abyte;
        logic [ADDR_W-1:0]   addr;
        logic [BLK_W-1:0]    blk;
        logic                wr;
        logic [1:0]          mode;
        logic                rsv;
        logic [BURST_W-1:0]  cnt;
        logic                wr_stb;
        logic                rd_stb;
        logic                rd_wait;
        logic [BYTE_W-1:0]   wdata;
    } ctl_t;

    ctl_t s_d, s_q;
    logic grant;

    always_comb begin
        grant = !s_q.rsv &&
                ((s_q.mode == 2'b00) || (s_q.cnt < burst_limit(s_q.mode)));
    end

    always_comb begin
        s_d         = s_q;
        s_d.wr_stb  = 1'b0;
        s_d.rd_stb  = 1'b0;
        s_d.rd_wait = s_q.rd_stb;
        tx_load     = 1'b0;
        tx_byte     = '0;

        if (s_q.wr_stb || s_q.rd_stb) begin
            s_d.addr = s_q.addr + ADDR_W'(1);
        end
        if (s_q.rd_wait) begin
            tx_load = 1'b1;
            tx_byte = bus_rdata;
        end

        if (!cs_act) begin
            s_d.phase   = PH_ADDR;
            s_d.abyte   = '0;
            s_d.rsv     = 1'b0;
            s_d.cnt     = '0;
            s_d.rd_wait = 1'b0;
        end else if (byte_done) begin
            case (s_q.phase)
                PH_ADDR: begin
                    s_d.addr = (s_q.addr << BYTE_W) | ADDR_W'(rx_byte);
                    if (s_q.abyte == ABYTE_W'(ABYTES - 1)) begin
                        s_d.phase = PH_CTRL;
                    end else begin
                        s_d.abyte = s_q.abyte + 1'b1;
                    end
                end
                PH_CTRL: begin
                    s_d.blk   = rx_byte[BYTE_W-1 -: BLK_W];
                    s_d.wr    = rx_byte[CTL_DIR];
                    s_d.mode  = rx_byte[1:0];
                    s_d.rsv   = blk_reserved(rx_byte[BYTE_W-1 -: BLK_W]);
                    s_d.cnt   = '0;
                    s_d.phase = PH_DATA;
                    if (!rx_byte[CTL_DIR] && !blk_reserved(rx_byte[BYTE_W-1 -: BLK_W])) begin
                        // first fetch: must land before the first data bit
                        s_d.rd_stb = 1'b1;
                        if (rx_byte[1:0] != 2'b00) begin
                            s_d.cnt = BURST_W'(1);
                        end
                    end else begin
                        tx_load = 1'b1;
                    end
                end
                PH_DATA: begin
                    if (s_q.wr) begin
                        if (grant) begin
                            s_d.wr_stb = 1'b1;
                            s_d.wdata  = rx_byte;
                        end
                    end else if (grant) begin
                        s_d.rd_stb = 1'b1;
                    end else begin
                        tx_load = 1'b1;
                    end
                    if (grant && (s_q.mode != 2'b00)) begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: s_d.phase = PH_ADDR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_ADDR;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_blk   = s_q.blk;
    assign bus_addr  = s_q.addr;
    assign bus_wr    = s_q.wr_stb;
    assign bus_wdata = s_q.wdata;
    assign bus_rd    = s_q.rd_stb;

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    assert_strobe_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |=> !(bus_wr || bus_rd));

    assert_strobe_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |-> $past(cs_act));

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |=> (bus_addr == $past(bus_addr) + ADDR_W'(1)));

    assert_burst_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.phase == PH_DATA) && (s_q.mode != 2'b00)) |-> (s_q.cnt <= burst_limit(s_q.mode)));

    assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rsv |-> !(bus_wr || bus_rd));

endmodule

// File: rtl/spi_frame_slave.sv
module spi_frame_slave
    import spi_frame_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [4:0]        bus_blk,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic [7:0]        bus_wdata,
    output logic              bus_rd,
    input  logic [7:0]        bus_rdata
);

    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              mosi_s;
    logic              tx_load;
    logic [BYTE_W-1:0] tx_byte;
    logic              byte_done;
    logic [BYTE_W-1:0] rx_byte;

    spi_frame_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk),
        .cs_n_i      (spi_cs_n),
        .mosi_i      (spi_mosi),
        .cs_act_o    (cs_act),
        .sclk_rise_o (sclk_rise),
        .sclk_fall_o (sclk_fall),
        .mosi_o      (mosi_s)
    );

    spi_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi      (mosi_s),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (spi_miso)
    );

    spi_frame_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .bus_rdata (bus_rdata),
        .tx_load   (tx_load),
        .tx_byte   (tx_byte),
        .bus_blk   (bus_blk),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd)
    );

endmodule

// File: tb/spi_frame_slave_test.sv
module spi_frame_slave_test;

    localparam int H = 8;  // system clocks per SCLK phase

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic [4:0] blk;
    logic [15:0] addr;
    logic       wr;
    logic [7:0] wdata;
    logic       rd;
    logic [7:0] rdata = 8'h00;

    always #10 clk = ~clk;

    spi_frame_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (sclk),
        .spi_cs_n  (cs_n),
        .spi_mosi  (mosi),
        .spi_miso  (miso),
        .bus_blk   (blk),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rd    (rd),
        .bus_rdata (rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int wr_cnt = 0, rd_cnt = 0, both_cnt = 0, idle_stb = 0;
    logic [15:0] wr_addr [0:15];
    logic [7:0]  wr_dat  [0:15];
    logic [4:0]  wr_blk  [0:15];
    logic [15:0] rd_addr [0:15];
    logic [7:0]  got [0:15];
    logic [7:0]  hdr [0:2];

    function automatic logic [7:0] rmodel(input logic [4:0] b, input logic [15:0] a);
        rmodel = a[7:0] ^ a[15:8] ^ {b, 3'b011};
    endfunction

    // bus model and strobe logger
    always @(negedge clk) begin
        if (wr && rd) both_cnt++;
        if ((wr || rd) && cs_n) idle_stb++;
        if (wr) begin
            if (wr_cnt < 16) begin
                wr_addr[wr_cnt] = addr;
                wr_dat[wr_cnt]  = wdata;
                wr_blk[wr_cnt]  = blk;
            end
            wr_cnt++;
        end
        if (rd) begin
            rdata = rmodel(blk, addr);
            if (rd_cnt < 16) rd_addr[rd_cnt] = addr;
            rd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic half();
        repeat (H) @(negedge clk);
    endtask

    task automatic xfer_bits(input logic [7:0] o, input int nbits, output logic [7:0] i);
        i = 8'h00;
        for (int b = 7; b > 7 - nbits; b--) begin
            mosi = o[b];
            half();
            sclk = 1'b1;
            i[b] = miso;
            half();
            sclk = 1'b0;
        end
    endtask

    task automatic end_frame();
        half();
        cs_n = 1'b1;
        repeat (4 * H) @(negedge clk);
    endtask

    task automatic do_frame(input logic [15:0] a, input logic [7:0] c, input int n, input logic [7:0] wbase);
        logic [7:0] r;
        wr_cnt = 0;
        rd_cnt = 0;
        cs_n = 1'b0;
        half();
        xfer_bits(a[15:8], 8, r); hdr[0] = r;
        xfer_bits(a[7:0], 8, r);  hdr[1] = r;
        xfer_bits(c, 8, r);       hdr[2] = r;
        for (int k = 0; k < n; k++) begin
            xfer_bits(c[2] ? (wbase + 8'(k)) : 8'hFF, 8, r);
            got[k] = r;
        end
        end_frame();
    endtask

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  c;
        logic [3:0]  n;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{16'h1234, 8'h0C, 4'd3},   // blk 1 write, open-ended
        '{16'h0020, 8'h00, 4'd4},   // blk 0 read, open-ended
        '{16'hFFFE, 8'h14, 4'd3},   // blk 2 write across wrap
        '{16'h0100, 8'h1D, 4'd3},   // blk 3 write, 1-byte cap
        '{16'h0200, 8'h2A, 4'd4},   // blk 5 read, 2-byte cap
        '{16'h0300, 8'h3B, 4'd5},   // blk 7 read, 4-byte cap
        '{16'h0400, 8'h24, 4'd2},   // blk 4 reserved write
        '{16'h0500, 8'h40, 4'd2},   // blk 8 reserved read
        '{16'hFFFF, 8'hF8, 4'd3}    // blk 31 read across wrap
    };

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(wr == 0 && rd == 0, "R10", "strobes in reset", {wr, rd}, 0);
        chk(addr == 0 && blk == 0 && wdata == 0, "R10", "bus outputs in reset", addr, 0);
        chk(miso == 1'b0, "R10", "miso in reset", miso, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            logic [4:0] b;
            logic       w, rsv;
            logic [1:0] m;
            int n, lim, acc, exp_wr, exp_rd;
            string tag;
            logic [7:0] wb;
            b   = VECS[v].c[7:3];
            w   = VECS[v].c[2];
            m   = VECS[v].c[1:0];
            n   = int'(VECS[v].n);
            rsv = (b[1:0] == 2'b00) && (b != 0);
            lim = (m == 2'b00) ? 1000 : (m == 2'b01) ? 1 : (m == 2'b10) ? 2 : 4;
            acc = rsv ? 0 : ((n < lim) ? n : lim);
            exp_wr = w ? acc : 0;
            exp_rd = (w || rsv) ? 0 : (((n + 1) < lim) ? n + 1 : lim);
            tag = rsv ? "R8" : (m != 2'b00) ? "R6" : "R5";
            wb  = 8'h50 + 8'(v * 16);

            do_frame(VECS[v].a, VECS[v].c, n, wb);

            chk(wr_cnt == exp_wr, tag, $sformatf("vec %0d write count", v), wr_cnt, exp_wr);
            chk(rd_cnt == exp_rd, w ? tag : "R3", $sformatf("vec %0d read count", v), rd_cnt, exp_rd);
            for (int k = 0; k < 3; k++)
                chk(hdr[k] == 8'h00, "R11", $sformatf("vec %0d header miso byte %0d", v, k), hdr[k], 0);
            if (w) begin
                for (int k = 0; k < exp_wr && k < 16; k++) begin
                    chk(wr_addr[k] == VECS[v].a + 16'(k), (k == 0) ? "R1" : "R4",
                        $sformatf("vec %0d write addr %0d", v, k), wr_addr[k], VECS[v].a + 16'(k));
                    chk(wr_dat[k] == wb + 8'(k), "R2", $sformatf("vec %0d write data %0d", v, k), wr_dat[k], wb + 8'(k));
                    chk(wr_blk[k] == b, "R1", $sformatf("vec %0d write blk %0d", v, k), wr_blk[k], b);
                end
                for (int k = 0; k < n; k++)
                    chk(got[k] == 8'h00, "R11", $sformatf("vec %0d write-phase miso %0d", v, k), got[k], 0);
            end else begin
                for (int k = 0; k < exp_rd && k < 16; k++)
                    chk(rd_addr[k] == VECS[v].a + 16'(k), (k == 0) ? "R1" : "R4",
                        $sformatf("vec %0d read addr %0d", v, k), rd_addr[k], VECS[v].a + 16'(k));
                for (int k = 0; k < n; k++) begin
                    logic [7:0] e;
                    e = (k < acc) ? rmodel(b, VECS[v].a + 16'(k)) : 8'h00;
                    chk(got[k] == e, (k < acc) ? "R3" : tag, $sformatf("vec %0d read byte %0d", v, k), got[k], e);
                end
            end
        end

        // R7: abort inside a data byte
        begin
            logic [7:0] r;
            wr_cnt = 0;
            cs_n = 1'b0; half();
            xfer_bits(8'h06, 8, r); xfer_bits(8'h00, 8, r); xfer_bits(8'h0C, 8, r);
            xfer_bits(8'hC3, 5, r);
            end_frame();
            chk(wr_cnt == 0, "R7", "write after mid-byte abort", wr_cnt, 0);

            // R7: abort inside the address, then a clean frame
            cs_n = 1'b0; half();
            xfer_bits(8'h99, 8, r); xfer_bits(8'h77, 3, r);
            end_frame();
            do_frame(16'h0700, 8'h14, 1, 8'h3C);
            chk(wr_cnt == 1, "R7", "write count after address abort", wr_cnt, 1);
            chk(wr_addr[0] == 16'h0700, "R7", "address after restart", wr_addr[0], 16'h0700);
            chk(wr_dat[0] == 8'h3C, "R7", "data after restart", wr_dat[0], 8'h3C);
        end

        // R9: strobe exclusivity and framing over the whole run
        chk(both_cnt == 0, "R9", "cycles with both strobes", both_cnt, 0);
        chk(idle_stb == 0, "R9", "strobes outside a frame", idle_stb, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule